// File: doc/BRIEF.md
# Per-Line MOESI Coherence Controller

This block holds the coherence state of one line in a private cache that takes part in a broadcast-style MOESI protocol. There are five stable states and eleven transient states. Each cycle may carry one decoded event. The event can come from the local processor, from a data move between the split first-level caches and the second-level cache, from another node's forwarded request, from a response, or from an internal completion trigger. From the event and the registered state, a combinational table gives the next state, a set of action strobes and a flag that marks an undefined combination.

The strobes tell the surrounding cache what to do. It may issue a shared or exclusive read request or a writeback request. It may answer a forwarded request with data or an ack, either plain, shared or exclusive. It may send an unblock, write the arriving fill data, or send the final writeback as normal or exclusive. It may claim or release the transaction entry, and pop or recycle its input queues. The access-permission output tells the cache whether the line may be read, written or neither. Data storage, the network and acknowledgement counting stay outside this block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: State encoding on `state_o`: I=0, S=1, O=2, M=3, MM=4, IM=5, SM=6, OM=7, ISM=8, M_W=9, MM_W=10, IS=11, SS=12, OI=13, MI=14, II=15. While `rst_n` is low the state is I, with permission 0 and all strobes 0.
- R2: `perm_o` is 2 (read-write) only in MM and MM_W. It is 1 (read-only) in S, O, M, SM, OM, ISM, SS and M_W. It is 0 (invalid) in every other state.
- R3: Event codes on `evt_code_i`: load 0, ifetch 1, store 2, replacement 3, L1-to-L2 move 4, L2-to-L1 data move 5, L2-to-L1 instruction move 6, remote GETX 7, remote GETS 8, ack 9, shared ack 10, data 11, shared data 12, exclusive data 13, writeback ack 14, writeback nack 15, all-acks with sharers 16, all-acks without sharers 17.
- R4: Strobe bits of `act_o`: 0 issue GETS, 1 issue GETX, 2 issue PUT, 3 send data, 4 send shared data, 5 send exclusive data, 6 send ack, 7 send shared ack, 8 unblock, 9 normal writeback, 10 exclusive writeback, 11 write fill, 12 claim entry, 13 release entry, 14 pop request queue, 15 recycle request, 16 pop forward queue, 17 pop response queue, 18 pop trigger queue.
- R5: Processor requests in stable states behave as follows. A load or ifetch in I goes to IS and issues GETS. A store in I goes to IM and issues GETX. Both claim the entry and pop the request. A store in S goes to SM, and a store in O goes to OM; each issues GETX, claims the entry and pops. A store in M goes to MM and only pops. Loads that hit (S, O, M, MM, SM, OM, ISM, SS, M_W, MM_W) only pop.
- R6: Remote requests in stable states behave as follows. A GETS in M sends shared data and goes to O. A GETS in MM sends exclusive data and goes to I. A GETX in M or MM sends exclusive data and goes to I. A GETX or GETS in I sends an ack and stays in I. Each of these pops the forward queue.
- R7: Fills behave as follows. In IS, data or shared data goes to SS and exclusive data goes to M_W. In IM, data goes to ISM and exclusive data goes to MM_W. Each writes the fill and pops the response queue. A remote GETX in SM sends an ack and goes to IM.
- R8: All-acks without sharers takes ISM to MM, MM_W to MM, M_W to M and SS to S. In OM, either completion event goes to MM. Each completion sends an unblock, releases the entry and pops the trigger queue.
- R9: Replacement takes O to OI, and takes M or MM to MI. Each of these issues PUT and claims the entry. In OI or MI, a remote GETX goes to II and a remote GETS goes to OI. Both send data and pop the forward queue.
- R10: A writeback ack in MI sends an exclusive writeback, and in OI a normal writeback. In II, either a writeback ack or a nack is accepted. All of these go to I, release the entry and pop the forward queue.
- R11: A store or replacement in any transient state is recycled. The one exception is a store in M_W or MM_W. A load or ifetch in IM, IS, OI, MI or II is also recycled. A recycle asserts only bit 15, and the state is unchanged.
- R12: An event with no defined transition for the current state, or a code above 17, sets `bad_evt_o`. It leaves all strobes 0 and the state unchanged.
- R13: With `evt_valid_i` low, all strobes and `bad_evt_o` are 0 and the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | An event is presented this cycle |
| evt_code_i | input | 5 | Decoded event code (R3) |
| state_o | output | 4 | Registered line state (R1) |
| perm_o | output | 2 | Access permission of the current state (R2) |
| act_o | output | 19 | Action strobes for the current event (R4) |
| bad_evt_o | output | 1 | Event undefined for the current state |

## Verification
The checker watches several rules on every cycle. Write permission appears only in the two write-capable states. An undefined event produces no strobe and does not move the state. A recycle holds the state. At most one queue operation occurs per cycle. The transaction entry is claimed only from a stable state and released only from a transient one. Idle cycles are silent. The exact row of the table cannot be seen from these rules: which successor and which strobe mask each state-event pair yields, such as M going to O on a remote GETS while MM goes to I. Those rows are shown only by the bench's scripted paths, which walk the line through each protocol branch and compare every step with a value worked out from the requirements.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  localparam int ST_W      = 4;
  localparam int EVT_W     = 5;
  localparam int PERM_W    = 2;
  localparam int EVT_COUNT = 18;

  typedef enum logic [ST_W-1:0] {
    ST_I   = 4'd0,  ST_S   = 4'd1,  ST_O   = 4'd2,  ST_M   = 4'd3,
    ST_MM  = 4'd4,  ST_IM  = 4'd5,  ST_SM  = 4'd6,  ST_OM  = 4'd7,
    ST_ISM = 4'd8,  ST_MW  = 4'd9,  ST_MMW = 4'd10, ST_IS  = 4'd11,
    ST_SS  = 4'd12, ST_OI  = 4'd13, ST_MI  = 4'd14, ST_II  = 4'd15
  } line_st_e;

  typedef enum logic [EVT_W-1:0] {
    EV_LOAD    = 5'd0,  EV_IFETCH  = 5'd1,  EV_STORE   = 5'd2,
    EV_REPL    = 5'd3,  EV_TO_L2   = 5'd4,  EV_TO_L1D  = 5'd5,
    EV_TO_L1I  = 5'd6,  EV_RGETX   = 5'd7,  EV_RGETS   = 5'd8,
    EV_ACK     = 5'd9,  EV_ACK_SH  = 5'd10, EV_DATA    = 5'd11,
    EV_DATA_SH = 5'd12, EV_DATA_EX = 5'd13, EV_WB_ACK  = 5'd14,
    EV_WB_NACK = 5'd15, EV_DONE_SH = 5'd16, EV_DONE_EX = 5'd17
  } line_ev_e;

  typedef enum logic [PERM_W-1:0] {
    PERM_NONE = 2'd0, PERM_RO = 2'd1, PERM_RW = 2'd2
  } perm_e;

  // Field order fixes the bit positions on act_o (first field = MSB).
  typedef struct packed {
    logic pop_trig;    // 18
    logic pop_rsp;     // 17
    logic pop_fwd;     // 16
    logic recycle_req; // 15
    logic pop_req;     // 14
    logic ent_free;    // 13
    logic ent_claim;   // 12
    logic fill;        // 11
    logic wb_excl;     // 10
    logic wb_norm;     // 9
    logic unblock;     // 8
    logic ack_sh;      // 7
    logic ack;         // 6
    logic data_ex;     // 5
    logic data_sh;     // 4
    logic data;        // 3
    logic put;         // 2
    logic getx;        // 1
    logic gets;        // 0
  } act_s;

  localparam int ACT_W = $bits(act_s);

  function automatic logic is_stable(line_st_e s);
    return s inside {ST_I, ST_S, ST_O, ST_M, ST_MM};
  endfunction
endpackage

// File: rtl/moesi_perm_map.sv
module moesi_perm_map
  import moesi_pkg::*;
(
  input  line_st_e st,
  output perm_e    perm
);
  always_comb begin
    if (st inside {ST_MM, ST_MMW})
      perm = PERM_RW;
    else if (st inside {ST_S, ST_O, ST_M, ST_SM, ST_OM, ST_ISM, ST_SS, ST_MW})
      perm = PERM_RO;
    else
      perm = PERM_NONE;
  end
endmodule

// File: rtl/moesi_event_table.sv
module moesi_event_table
  import moesi_pkg::*;
(
  input  line_st_e         cur_st,
  input  logic             evt_valid,
  input  logic [EVT_W-1:0] evt_code,
  output line_st_e         nxt_st,
  output act_s             acts,
  output logic             defined
);
  line_ev_e ev;
  logic     in_range, stable, is_load, recyc, move_ok, hit, ack_ok;

  always_comb begin
    ev       = line_ev_e'(evt_code);
    in_range = (int'(evt_code) < EVT_COUNT);
    stable   = is_stable(cur_st);
    is_load  = (ev == EV_LOAD) || (ev == EV_IFETCH);
    recyc    = (!stable && (ev == EV_REPL || ev == EV_TO_L2 ||
                (ev == EV_STORE && !(cur_st inside {ST_MW, ST_MMW})))) ||
               (is_load && (cur_st inside {ST_IM, ST_IS, ST_OI, ST_MI, ST_II}));
    move_ok  = stable && (ev inside {EV_TO_L2, EV_TO_L1D, EV_TO_L1I});
    hit      = is_load && (cur_st inside {ST_S, ST_O, ST_M, ST_MM, ST_SM, ST_OM,
                                          ST_ISM, ST_SS, ST_MW, ST_MMW});
    ack_ok   = ((ev == EV_ACK) && (cur_st inside {ST_IM, ST_SM, ST_ISM, ST_OM,
                                                  ST_IS, ST_SS, ST_MW, ST_MMW})) ||
               ((ev == EV_ACK_SH) && (cur_st inside {ST_IS, ST_SS}));
  end

  always_comb begin
    nxt_st  = cur_st;
    acts    = '0;
    defined = 1'b0;
    if (evt_valid && in_range) begin
      if (recyc) begin
        acts.recycle_req = 1'b1; defined = 1'b1;
      end else if (move_ok) begin
        defined = 1'b1;
      end else if (hit) begin
        acts.pop_req = 1'b1; defined = 1'b1;
      end else if (ack_ok) begin
        acts.pop_rsp = 1'b1; defined = 1'b1;
      end else begin
        defined = 1'b1;
        case (cur_st)
          ST_I: case (ev)
            EV_LOAD, EV_IFETCH: begin nxt_st = ST_IS; acts.gets = 1'b1; acts.ent_claim = 1'b1; acts.pop_req = 1'b1; end
            EV_STORE:           begin nxt_st = ST_IM; acts.getx = 1'b1; acts.ent_claim = 1'b1; acts.pop_req = 1'b1; end
            EV_REPL:            ;
            EV_RGETX, EV_RGETS: begin acts.ack = 1'b1; acts.pop_fwd = 1'b1; end
            default:            defined = 1'b0;
          endcase
          ST_S: case (ev)
            EV_STORE: begin nxt_st = ST_SM; acts.getx = 1'b1; acts.ent_claim = 1'b1; acts.pop_req = 1'b1; end
            EV_REPL:  nxt_st = ST_I;
            EV_RGETX: begin nxt_st = ST_I; acts.ack = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETS: begin acts.ack_sh = 1'b1; acts.pop_fwd = 1'b1; end
            default:  defined = 1'b0;
          endcase
          ST_O: case (ev)
            EV_STORE: begin nxt_st = ST_OM; acts.getx = 1'b1; acts.ent_claim = 1'b1; acts.pop_req = 1'b1; end
            EV_REPL:  begin nxt_st = ST_OI; acts.put = 1'b1; acts.ent_claim = 1'b1; end
            EV_RGETX: begin nxt_st = ST_I; acts.data = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETS: begin acts.data_sh = 1'b1; acts.pop_fwd = 1'b1; end
            default:  defined = 1'b0;
          endcase
          ST_M, ST_MM: case (ev)
            EV_STORE: begin nxt_st = ST_MM; acts.pop_req = 1'b1; end
            EV_REPL:  begin nxt_st = ST_MI; acts.put = 1'b1; acts.ent_claim = 1'b1; end
            EV_RGETX: begin nxt_st = ST_I; acts.data_ex = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETS: begin
              acts.pop_fwd = 1'b1;
              if (cur_st == ST_M) begin nxt_st = ST_O; acts.data_sh = 1'b1; end
              else begin nxt_st = ST_I; acts.data_ex = 1'b1; end
            end
            default:  defined = 1'b0;
          endcase
          ST_IM, ST_IS: case (ev)
            EV_RGETX, EV_RGETS: begin acts.ack = 1'b1; acts.pop_fwd = 1'b1; end
            EV_DATA:    begin nxt_st = (cur_st == ST_IM) ? ST_ISM : ST_SS; acts.fill = 1'b1; acts.pop_rsp = 1'b1; end
            EV_DATA_EX: begin nxt_st = (cur_st == ST_IM) ? ST_MMW : ST_MW; acts.fill = 1'b1; acts.pop_rsp = 1'b1; end
            EV_DATA_SH: begin
              if (cur_st == ST_IS) begin nxt_st = ST_SS; acts.fill = 1'b1; acts.pop_rsp = 1'b1; end
              else defined = 1'b0;
            end
            default:    defined = 1'b0;
          endcase
          ST_SM: case (ev)
            EV_RGETS: begin acts.ack_sh = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETX: begin nxt_st = ST_IM; acts.ack = 1'b1; acts.pop_fwd = 1'b1; end
            EV_DATA:  begin nxt_st = ST_ISM; acts.fill = 1'b1; acts.pop_rsp = 1'b1; end
            default:  defined = 1'b0;
          endcase
          ST_OM: case (ev)
            EV_RGETX: begin nxt_st = ST_IM; acts.data = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETS: begin acts.data_sh = 1'b1; acts.pop_fwd = 1'b1; end
            EV_DONE_SH, EV_DONE_EX: begin nxt_st = ST_MM; acts.unblock = 1'b1; acts.ent_free = 1'b1; acts.pop_trig = 1'b1; end
            default:  defined = 1'b0;
          endcase
          ST_ISM, ST_MMW, ST_MW, ST_SS: begin
            if (ev == EV_DONE_EX || (ev == EV_DONE_SH && cur_st == ST_SS)) begin
              acts.unblock = 1'b1; acts.ent_free = 1'b1; acts.pop_trig = 1'b1;
              nxt_st = (cur_st == ST_SS) ? ST_S : (cur_st == ST_MW) ? ST_M : ST_MM;
            end else if (ev == EV_STORE && cur_st == ST_MW) begin
              nxt_st = ST_MMW; acts.pop_req = 1'b1;
            end else if (ev == EV_STORE && cur_st == ST_MMW) begin
              acts.pop_req = 1'b1;
            end else begin
              defined = 1'b0;
            end
          end
          ST_OI, ST_MI: case (ev)
            EV_RGETX:  begin nxt_st = ST_II; acts.data = 1'b1; acts.pop_fwd = 1'b1; end
            EV_RGETS:  begin nxt_st = ST_OI; acts.data = 1'b1; acts.pop_fwd = 1'b1; end
            EV_WB_ACK: begin
              nxt_st = ST_I; acts.ent_free = 1'b1; acts.pop_fwd = 1'b1;
              if (cur_st == ST_MI) acts.wb_excl = 1'b1; else acts.wb_norm = 1'b1;
            end
            default:   defined = 1'b0;
          endcase
          ST_II: case (ev)
            EV_RGETX, EV_RGETS:    begin acts.ack = 1'b1; acts.pop_fwd = 1'b1; end
            EV_WB_ACK, EV_WB_NACK: begin nxt_st = ST_I; acts.ent_free = 1'b1; acts.pop_fwd = 1'b1; end
            default:               defined = 1'b0;
          endcase
          default: defined = 1'b0;
        endcase
        if (!defined) begin
          nxt_st = cur_st;
          acts   = '0;
        end
      end
    end
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid_i,
  input  logic [EVT_W-1:0]  evt_code_i,
  output logic [ST_W-1:0]   state_o,
  output logic [PERM_W-1:0] perm_o,
  output logic [ACT_W-1:0]  act_o,
  output logic              bad_evt_o
);
  line_st_e st_q, st_d;
  act_s     acts;
  perm_e    perm;
  logic     defined, st_en;

  moesi_event_table u_table (
    .cur_st    (st_q),
    .evt_valid (evt_valid_i),
    .evt_code  (evt_code_i),
    .nxt_st    (st_d),
    .acts      (acts),
    .defined   (defined)
  );

  moesi_perm_map u_perm (
    .st   (st_q),
    .perm (perm)
  );

  assign st_en = evt_valid_i & defined;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_I;
    else if (st_en) st_q <= st_d;
  end

  assign state_o   = st_q;
  assign perm_o    = perm;
  assign act_o     = acts;
  assign bad_evt_o = evt_valid_i & ~defined;
endmodule

// File: rtl/moesi_line_ctrl_sva.sv
module moesi_line_ctrl_sva
  import moesi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid_i,
  input logic [ST_W-1:0]   state_o,
  input logic [PERM_W-1:0] perm_o,
  input logic [ACT_W-1:0]  act_o,
  input logic              bad_evt_o
);
  logic stable_now;
  assign stable_now = (state_o <= 4'd4);

  assert_rw_only_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_o == 2'd2) |-> (state_o == 4'd4 || state_o == 4'd10));

  assert_bad_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt_o |-> (act_o == '0));

  assert_bad_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt_o |=> (state_o == $past(state_o)));

  assert_recycle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[15] |=> (state_o == $past(state_o)));

  assert_one_queue_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({act_o[18:14]}) <= 1);

  assert_claim_from_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[12] |-> stable_now);

  assert_free_from_transient_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[13] |-> !stable_now);

  assert_idle_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid_i |-> (act_o == '0 && !bad_evt_o));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid_i |=> $stable(state_o));
endmodule

bind moesi_line_ctrl moesi_line_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid_i (evt_valid_i),
  .state_o     (state_o),
  .perm_o      (perm_o),
  .act_o       (act_o),
  .bad_evt_o   (bad_evt_o)
);

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid_i;
  logic [4:0]  evt_code_i;
  logic [3:0]  state_o;
  logic [1:0]  perm_o;
  logic [18:0] act_o;
  logic        bad_evt_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  moesi_line_ctrl u_moesi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i),
    .state_o(state_o), .perm_o(perm_o), .act_o(act_o), .bad_evt_o(bad_evt_o)
  );

  // states (R1)
  localparam logic [3:0] I=0, S=1, O=2, M=3, MM=4, IM=5, SM=6, OM=7, ISM=8,
                         MW=9, MMW=10, IS=11, SS=12, OI=13, MI=14, II=15;
  // events (R3)
  localparam logic [4:0] LD=0, IF=1, ST=2, RP=3, TO_L2=4, RGX=7, RGS=8, ACK=9, ACKS=10,
                         DAT=11, DSH=12, DEX=13, WBA=14, WBN=15, DNS=16, DNX=17;
  // strobes (R4)
  localparam logic [18:0] A_GETS=19'h1, A_GETX=19'h2, A_PUT=19'h4, A_DATA=19'h8,
    A_DSH=19'h10, A_DEX=19'h20, A_ACK=19'h40, A_ACKSH=19'h80, A_UNBL=19'h100,
    A_WBN=19'h200, A_WBX=19'h400, A_FILL=19'h800, A_CLAIM=19'h1000, A_FREE=19'h2000,
    A_PREQ=19'h4000, A_RECY=19'h8000, A_PFWD=19'h10000, A_PRSP=19'h20000, A_PTRG=19'h40000;

  typedef struct {
    string       tag;
    logic [18:0] act;
    logic        bad;
    logic [3:0]  st;
    logic [1:0]  pm;
  } exp_t;
  exp_t sb[$];

  function automatic logic [1:0] perm_of(input logic [3:0] s);
    if (s == MM || s == MMW) return 2'd2;
    if (s inside {S, O, M, SM, OM, ISM, SS, MW}) return 2'd1;
    return 2'd0;
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // driver: present one event and push its expectation
  task automatic ev(input string tag, input logic vld, input logic [4:0] code,
                    input logic [3:0] nst, input logic [18:0] act, input logic bad);
    exp_t e;
    @(negedge clk);
    evt_valid_i = vld;
    evt_code_i  = code;
    e.tag = tag; e.act = act; e.bad = bad; e.st = nst; e.pm = perm_of(nst);
    sb.push_back(e);
  endtask

  // monitor: strobes mid-cycle, state after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb[0];
        checks++;
        if (act_o !== e.act || bad_evt_o !== e.bad)
          fail(e.tag, "act/bad", {act_o, bad_evt_o}, {e.act, e.bad});
        @(posedge clk);
        #1;
        checks++;
        if (state_o !== e.st || perm_o !== e.pm)
          fail(e.tag, "state/perm", {state_o, perm_o}, {e.st, e.pm});
        void'(sb.pop_front());
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fail("watchdog", "timeout", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; evt_valid_i = 1'b0; evt_code_i = '0;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (state_o !== I || perm_o !== 2'd0 || act_o !== '0)
      fail("R1", "reset", {state_o, perm_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    ev("R13 idle",          0, ST,  I,   '0, 0);
    ev("R5 load miss",      1, LD,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R11 load in IS",    1, LD,  IS,  A_RECY, 0);
    ev("R7 IS excl data",   1, DEX, MW,  A_FILL|A_PRSP, 0);
    ev("R5 hit in M_W",     1, LD,  MW,  A_PREQ, 0);
    ev("R5 ack in M_W",     1, ACK, MW,  A_PRSP, 0);
    ev("R11 repl in M_W",   1, RP,  MW,  A_RECY, 0);
    ev("R12 shared done",   1, DNS, MW,  '0, 1);
    ev("R8 M_W done",       1, DNX, M,   A_UNBL|A_FREE|A_PTRG, 0);
    ev("R5 silent store",   1, ST,  MM,  A_PREQ, 0);
    ev("R9 repl MM",        1, RP,  MI,  A_PUT|A_CLAIM, 0);
    ev("R11 store in MI",   1, ST,  MI,  A_RECY, 0);
    ev("R11 load in MI",    1, IF,  MI,  A_RECY, 0);
    ev("R9 GETS in MI",     1, RGS, OI,  A_DATA|A_PFWD, 0);
    ev("R9 GETX in OI",     1, RGX, II,  A_DATA|A_PFWD, 0);
    ev("R10 GETS in II",    1, RGS, II,  A_ACK|A_PFWD, 0);
    ev("R10 nack in II",    1, WBN, I,   A_FREE|A_PFWD, 0);
    ev("R12 data in I",     1, DAT, I,   '0, 1);
    ev("R12 code 25",       1, 5'd25, I, '0, 1);
    ev("R5 L1-to-L2 in I",  1, TO_L2, I, '0, 0);
    ev("R6 GETX in I",      1, RGX, I,   A_ACK|A_PFWD, 0);
    ev("R5 store miss",     1, ST,  IM,  A_GETX|A_CLAIM|A_PREQ, 0);
    ev("R7 IM data",        1, DAT, ISM, A_FILL|A_PRSP, 0);
    ev("R5 hit in ISM",     1, LD,  ISM, A_PREQ, 0);
    ev("R8 ISM done",       1, DNX, MM,  A_UNBL|A_FREE|A_PTRG, 0);
    ev("R6 GETS in MM",     1, RGS, I,   A_DEX|A_PFWD, 0);
    ev("R5 ifetch miss",    1, IF,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R7 IS shared data", 1, DSH, SS,  A_FILL|A_PRSP, 0);
    ev("R7 SS shared ack",  1, ACKS, SS, A_PRSP, 0);
    ev("R8 SS done",        1, DNS, S,   A_UNBL|A_FREE|A_PTRG, 0);
    ev("R5 store in S",     1, ST,  SM,  A_GETX|A_CLAIM|A_PREQ, 0);
    ev("R7 GETX in SM",     1, RGX, IM,  A_ACK|A_PFWD, 0);
    ev("R7 IM excl data",   1, DEX, MMW, A_FILL|A_PRSP, 0);
    ev("R5 store in MM_W",  1, ST,  MMW, A_PREQ, 0);
    ev("R8 MM_W done",      1, DNX, MM,  A_UNBL|A_FREE|A_PTRG, 0);
    ev("R6 GETX in MM",     1, RGX, I,   A_DEX|A_PFWD, 0);
    ev("R5 load miss 2",    1, LD,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R7 IS excl 2",      1, DEX, MW,  A_FILL|A_PRSP, 0);
    ev("R8 M_W done 2",     1, DNX, M,   A_UNBL|A_FREE|A_PTRG, 0);
    ev("R6 GETS in M",      1, RGS, O,   A_DSH|A_PFWD, 0);
    ev("R5 store in O",     1, ST,  OM,  A_GETX|A_CLAIM|A_PREQ, 0);
    ev("R8 OM shared done", 1, DNS, MM,  A_UNBL|A_FREE|A_PTRG, 0);
    ev("R9 repl MM 2",      1, RP,  MI,  A_PUT|A_CLAIM, 0);
    ev("R10 ack in MI",     1, WBA, I,   A_WBX|A_FREE|A_PFWD, 0);
    ev("R5 load miss 3",    1, LD,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R7 IS data",        1, DAT, SS,  A_FILL|A_PRSP, 0);
    ev("R8 SS excl done",   1, DNX, S,   A_UNBL|A_FREE|A_PTRG, 0);
    ev("R6 GETX in S",      1, RGX, I,   A_ACK|A_PFWD, 0);
    ev("R5 load miss 4",    1, LD,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R7 IS excl 4",      1, DEX, MW,  A_FILL|A_PRSP, 0);
    ev("R5 store in M_W",   1, ST,  MMW, A_PREQ, 0);
    ev("R8 MM_W done 2",    1, DNX, MM,  A_UNBL|A_FREE|A_PTRG, 0);
    ev("R9 GETS to I",      1, RGS, I,   A_DEX|A_PFWD, 0);
    ev("R5 load miss 5",    1, LD,  IS,  A_GETS|A_CLAIM|A_PREQ, 0);
    ev("R7 IS excl 5",      1, DEX, MW,  A_FILL|A_PRSP, 0);
    ev("R8 M_W done 5",     1, DNX, M,   A_UNBL|A_FREE|A_PTRG, 0);
    ev("R6 GETS M to O",    1, RGS, O,   A_DSH|A_PFWD, 0);
    ev("R2 idle in O",      0, ST,  O,   '0, 0);
    ev("R9 repl O",         1, RP,  OI,  A_PUT|A_CLAIM, 0);
    ev("R10 ack in OI",     1, WBA, I,   A_WBN|A_FREE|A_PFWD, 0);

    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule